// File: doc/BRIEF.md
# Collision Vector Initiation Controller

This block decides, cycle by cycle, whether a new task may enter a static non-linear pipeline whose stages are reused at fixed offsets after an initiation. The pipeline's forbidden initiation latencies are supplied as a parameter bit vector. Bit i-1 of this vector is 1 when starting a second task i cycles after a first one would make two tasks claim the same stage.

The controller keeps a state vector of the same length. Every clock the state moves one position toward bit 0, and a zero enters at the top. A request is granted in the same cycle when bit 0 of the state is zero. On a grant, the shifted state is ORed with the parameter vector, so the latest initiation's forbidden latencies are added to those still pending. A requester that is refused simply holds its request and retries on the following cycle. A saturating count of cycles since the last grant is exported, so the latency between initiations can be observed.

Top module: `latency_gate`

## Requirements
- R1: While `rst` is high on a clock edge, the state is cleared to all zeros and `since_o` is set to its saturated value, all ones (255 for the default width of 8).
- R2: `grant_o` is high in a cycle exactly when `req_i` is high and bit 0 of `state_o` is 0 in that same cycle.
- R3: After a cycle without a grant, `state_o` equals its previous value shifted right by one position, with 0 entering at the most significant bit. A state of all zeros therefore stays all zeros while no task is started.
- R4: After a cycle with a grant, `state_o` equals the previous value shifted right by one position, bitwise ORed with the parameter vector `INIT_CV`.
- R5: A request made after reset, or after the state has decayed to all zeros, is granted at once, and the next state equals `INIT_CV`.
- R6: With the default vector 8'b10110001 (bit i-1 set means latency i is forbidden), a request made L cycles after a single initiation from an all-zero state is refused for L in {1,5,6,8} and granted for L in {2,3,4,7} and for every L of 9 or more. A grant at L = 9 leaves the state equal to `INIT_CV`.
- R7: `since_o` reads 1 in the cycle after a grant, rises by one each following cycle without a grant, and holds at all ones once it reaches that value. A request made L cycles after the last grant sees `since_o` equal to L.
- R8: With the default vector, initiations at latencies 3, 4 and 3 after a first initiation leave the states 10110111, 10111011 and 10110111. A request held high continuously is granted 0, 2, 4, 11, 13, 15 and 22 cycles after the first grant, and the state after the third grant is 10111111.
- R9: `grant_o` is never high while `req_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request to start a task in this cycle |
| grant_o | output | 1 | Task start permitted in this cycle (combinational) |
| state_o | output | LEN | Current forbidden-latency state vector |
| since_o | output | CNT_W | Saturating count of cycles since the last grant |

## Verification
The bound checker tests the grant rule, the shift and merge update of the state, the counter's step, reset to 1 and saturation, and that no grant ever lands on a latency marked in the parameter vector relative to the previous grant. These hold on every cycle for any vector. The bench's scenarios show what the per-cycle rules cannot show alone: the full set of admitted and refused latencies for the default vector, the exact state values along multi-step initiation chains, the grant pattern under a request held high, and the return to the initial state after a long gap.

// File: rtl/latency_gate_pkg.sv
package latency_gate_pkg;
  // Default geometry: forbidden latencies {1,5,6,8}, bit i-1 marks latency i.
  parameter int unsigned   LG_DEF_LEN   = 8;
  parameter logic [7:0]    LG_DEF_CV    = 8'b1011_0001;
  parameter int unsigned   LG_DEF_CNT_W = 8;
endpackage

// File: rtl/lg_admit.sv
module lg_admit #(
  parameter int unsigned LEN = 8
) (
  input  logic [LEN-1:0] state_i,
  input  logic           req_i,
  output logic           grant_o
);
  // The bit that leaves the state this cycle tells whether this latency is free.
  always_comb grant_o = req_i & ~state_i[0];
endmodule

// File: rtl/lg_state_reg.sv
module lg_state_reg #(
  parameter int unsigned   LEN     = 8,
  parameter logic [LEN-1:0] INIT_CV = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           grant_i,
  output logic [LEN-1:0] state_o
);
  logic [LEN-1:0] nxt;

  // Per bit: take the upper neighbour (zero at the top), add the vector on a start.
  for (genvar i = 0; i < LEN; i++) begin : g_bit
    if (i == LEN - 1) begin : g_top
      always_comb nxt[i] = grant_i & INIT_CV[i];
    end else begin : g_mid
      always_comb nxt[i] = state_o[i+1] | (grant_i & INIT_CV[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_o <= '0;
    else     state_o <= nxt;
  end
endmodule

// File: rtl/lg_since_ctr.sv
module lg_since_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_i,
  output logic [CNT_W-1:0] since_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)               since_o <= SAT;
    else if (grant_i)      since_o <= ONE;
    else if (since_o != SAT) since_o <= since_o + ONE;
  end
endmodule

// File: rtl/latency_gate.sv
module latency_gate
  import latency_gate_pkg::*;
#(
  parameter int unsigned    LEN     = LG_DEF_LEN,
  parameter logic [LEN-1:0] INIT_CV = LEN'(LG_DEF_CV),
  parameter int unsigned    CNT_W   = LG_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  output logic             grant_o,
  output logic [LEN-1:0]   state_o,
  output logic [CNT_W-1:0] since_o
);
  logic gnt;

  lg_admit #(.LEN(LEN)) u_admit (
    .state_i (state_o),
    .req_i   (req_i),
    .grant_o (gnt)
  );

  lg_state_reg #(.LEN(LEN), .INIT_CV(INIT_CV)) u_state (
    .clk     (clk),
    .rst     (rst),
    .grant_i (gnt),
    .state_o (state_o)
  );

  lg_since_ctr #(.CNT_W(CNT_W)) u_since (
    .clk     (clk),
    .rst     (rst),
    .grant_i (gnt),
    .since_o (since_o)
  );

  assign grant_o = gnt;
endmodule

// File: rtl/latency_gate_chk.sv
module latency_gate_chk #(
  parameter int unsigned    LEN     = 8,
  parameter logic [LEN-1:0] INIT_CV = '0,
  parameter int unsigned    CNT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_i,
  input logic             grant_o,
  input logic [LEN-1:0]   state_o,
  input logic [CNT_W-1:0] since_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  // Is the latency since the last grant one the vector marks as forbidden?
  logic marked;
  always_comb begin
    marked = 1'b0;
    for (int i = 0; i < int'(LEN); i++)
      if (since_o == CNT_W'(i + 1)) marked = INIT_CV[i];
  end

  assert_free_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (req_i && !state_o[0]) |-> grant_o);
  assert_busy_deny_R2: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> !state_o[0]);
  assert_no_req_no_grant_R9: assert property (@(posedge clk) disable iff (rst)
    !req_i |-> !grant_o);
  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    !grant_o |=> state_o == ($past(state_o) >> 1));
  assert_merge_R4: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> state_o == (($past(state_o) >> 1) | INIT_CV));
  assert_fresh_start_R5: assert property (@(posedge clk) disable iff (rst)
    (grant_o && state_o == '0) |=> state_o == INIT_CV);
  assert_not_forbidden_R6: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> !marked);
  assert_since_reload_R7: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> since_o == CNT_W'(1));
  assert_since_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!grant_o && since_o != SAT) |=> since_o == $past(since_o) + CNT_W'(1));
  assert_since_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!grant_o && since_o == SAT) |=> since_o == SAT);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (state_o == '0 && since_o == SAT));
endmodule

bind latency_gate latency_gate_chk #(.LEN(LEN), .INIT_CV(INIT_CV), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_i   (req_i),
  .grant_o (grant_o),
  .state_o (state_o),
  .since_o (since_o)
);

// File: tb/latency_gate_test.sv
`timescale 1ns/1ps
module latency_gate_test;
  localparam int LEN = 8;
  localparam int CW  = 8;
  localparam logic [7:0] CV = 8'b1011_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic grant;
  logic [LEN-1:0] state;
  logic [CW-1:0]  since;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  latency_gate uut (
    .clk(clk), .rst(rst), .req_i(req),
    .grant_o(grant), .state_o(state), .since_o(since)
  );

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%0d (0x%0h) exp=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // One cycle: drive at negedge, sample before the edge, then just after it.
  task automatic step(input bit r, output bit g, output int pre_st,
                      output int pre_since, output int post_st);
    @(negedge clk);
    req = r;
    #1;
    g = grant; pre_st = int'(state); pre_since = int'(since);
    @(posedge clk);
    #1;
    post_st = int'(state);
  endtask

  task automatic do_reset();
    rst = 1'b1; req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic bit forbidden(int lat);
    return (lat == 1 || lat == 5 || lat == 6 || lat == 8);
  endfunction

  // Idle lat-1 cycles then request; returns grant, pre-edge since and post state.
  task automatic after(input int lat, output bit g, output int sn, output int post);
    bit gi; int a, b, c;
    for (int k = 1; k < lat; k++) step(1'b0, gi, a, b, c);
    step(1'b1, g, a, sn, post);
  endtask

  task automatic t_reset();
    bit g; int ps, sn, po;
    do_reset();
    step(1'b0, g, ps, sn, po);
    chk(ps == 0, "R1 state after reset", ps, 0);
    chk(sn == 255, "R1 since after reset", sn, 255);
    chk(g == 1'b0, "R9 no grant without request", g, 0);
    step(1'b1, g, ps, sn, po);
    chk(g == 1'b1, "R5 first request granted", g, 1);
    chk(po == int'(CV), "R5 state loads vector", po, int'(CV));
    step(1'b0, g, ps, sn, po);
    chk(sn == 1, "R7 since is 1 after grant", sn, 1);
    chk(po == int'(CV >> 1), "R3 idle shift", po, int'(CV >> 1));
  endtask

  task automatic t_latency();
    for (int lat = 1; lat <= 10; lat++) begin
      bit g; int ps, sn, po;
      do_reset();
      step(1'b1, g, ps, sn, po);
      after(lat, g, sn, po);
      chk(g == !forbidden(lat), $sformatf("R6 latency %0d admission", lat), g, !forbidden(lat));
      chk(sn == lat, $sformatf("R7 since at latency %0d", lat), sn, lat);
      if (g && lat >= 9) chk(po == int'(CV), "R6 long gap returns to initial", po, int'(CV));
      if (lat == 2) chk(po == 8'hBD, "R4 merge at latency 2", po, 8'hBD);
    end
  endtask

  task automatic t_chain();
    bit g; int ps, sn, po;
    do_reset();
    step(1'b1, g, ps, sn, po);
    after(3, g, sn, po);
    chk(g && po == 8'hB7, "R8 chain step latency 3", po, 8'hB7);
    after(4, g, sn, po);
    chk(g && po == 8'hBB, "R8 chain step latency 4", po, 8'hBB);
    after(3, g, sn, po);
    chk(g && po == 8'hB7, "R8 chain step latency 3 again", po, 8'hB7);
  endtask

  task automatic t_retry();
    bit g; int ps, sn, po;
    int grants = 0;
    do_reset();
    for (int i = 0; i <= 22; i++) begin
      bit exp_g;
      step(1'b1, g, ps, sn, po);
      exp_g = (i == 0 || i == 2 || i == 4 || i == 11 || i == 13 || i == 15 || i == 22);
      if (g != exp_g) chk(1'b0, $sformatf("R8 held request cycle %0d", i), g, exp_g);
      if (g) grants++;
      if (i == 4) chk(po == 8'hBF, "R8 state after third grant", po, 8'hBF);
      if (i == 11) chk(po == int'(CV), "R8 latency 7 back to initial", po, int'(CV));
    end
    chk(grants == 7, "R2 grant count under held request", grants, 7);
  endtask

  task automatic t_saturate();
    bit g; int ps, sn, po;
    do_reset();
    step(1'b1, g, ps, sn, po);
    for (int k = 0; k < 300; k++) step(1'b0, g, ps, sn, po);
    chk(g == 1'b0, "R9 idle no grant", g, 0);
    step(1'b0, g, ps, sn, po);
    chk(sn == 255, "R7 since saturates", sn, 255);
    chk(ps == 0, "R3 state decays to zero", ps, 0);
    step(1'b1, g, ps, sn, po);
    chk(g == 1'b1 && po == int'(CV), "R5 restart after decay", po, int'(CV));
  endtask

  initial begin
    t_reset();
    t_latency();
    t_chain();
    t_retry();
    t_saturate();
    report();
    $finish;
  end
endmodule